// File: doc/BRIEF.md
# Cluster Bring-Up and Boot Arbiter

This block takes one boot request at a time for any core of a multi-cluster processor complex and decides how much work the request needs. It keeps an online count for every core. A request for a core that is already online only bumps that core's count. A request for an offline core first checks whether its whole cluster is empty. If it is, the block marks the request as the first one into the cluster and walks the cluster through its power-up steps. It then hands the core to an external per-core sequencer and waits for that sequencer to report completion.

The cluster power-up drives a small register model per cluster: a control word with the reset-disable bits, a control word with the snoop-inactive bit, a reset word that is active low, a core power-on reset vector that is active low, and a power-gate word. The steps run in a fixed order, one step per clock. The only exception is the gate settle wait, which is counted in microsecond ticks. One core can be marked as already online at reset through configuration pins, so the cluster that boots the system never gets a second power-up.

Top module: `cluster_boot_arbiter`

## Requirements
- R1: A request whose cluster index is N_CLUSTERS or more, or whose core index is CORES_PER_CLUSTER or more, ends with `done_o` and `err_o` high together. It issues no core start and changes no count, no register and no first-comer flag.
- R2: A request for a core whose count is nonzero ends with `done_o` and no core start. It leaves every register and the first-comer flag unchanged.
- R3: A request for an offline core in a cluster whose counts are all zero sets `first_comer_o` to 1 and runs the cluster power-up before the core start. A request for an offline core in a cluster with any nonzero count sets `first_comer_o` to 0 and goes straight to the core start, with no register change.
- R4: The core hand-off is a one-cycle `core_start_o` pulse carrying the request's cluster and core. `done_o` rises only after `core_seq_done_i` has been seen. `done_o` stays low and `req_ready_o` stays high out of reset.
- R5: Bit 0 of the control-1 word (snoop inactive, reset 0) is set as the first power-up step. It is cleared as the last power-up step, after the resets are released, and is 0 when the request completes.
- R6: The reset word (active low, reset value 0x01FF11FF) is handled in two steps. Power-up clears bits 24, 19..16, 12 and 8, and also clears bits 23..20 when the cluster is little-type (`cluster_little_i` bit = 1). After the gate wait, power-up sets bits 24, 12 and 8 again. The debug and trace bits stay cleared.
- R7: The reset-disable bits of the control-0 word (reset value 0x1F) are cleared after the resets are asserted. A big-type cluster clears bit 0 only. A little-type cluster clears bits 3..0 and bit 4.
- R8: Power-up clears all core power-on reset bits (reset value all ones) before the resets are asserted. It clears the cluster bit 4 of the power-gate word (reset value 0x1F, core bits 3..0 untouched) after the reset-disable step. The resets are released only after exactly GATE_WAIT_US ticks of `us_tick_i` have been counted following the gate clear.
- R9: A core's count goes up by one when its request completes, whether or not power-up ran. A second request for the same core therefore behaves as R2.
- R10: `req_ready_o` is low from the cycle after a request is accepted until after `done_o`.
- R11: The core named by `boot_cluster_i`/`boot_core_i` comes out of reset with a count of 1. All other counts start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_cluster_i | input | CL_W | Cluster of the core that is online at reset |
| boot_core_i | input | CO_W | Core that is online at reset |
| cluster_little_i | input | N_CLUSTERS | Per-cluster core type, 1 = little |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| req_valid_i | input | 1 | Boot request valid |
| req_ready_o | output | 1 | Arbiter idle, request accepted when valid |
| req_cluster_i | input | CL_W+1 | Requested cluster index |
| req_core_i | input | CO_W+1 | Requested core index |
| done_o | output | 1 | Request complete, one cycle |
| err_o | output | 1 | With done_o: index out of range |
| first_comer_o | output | 1 | Last accepted boot opened an empty cluster |
| core_start_o | output | 1 | One-cycle start for the per-core sequencer |
| core_start_cluster_o | output | CL_W | Cluster for the core start |
| core_start_core_o | output | CO_W | Core for the core start |
| core_seq_done_i | input | 1 | Per-core sequencer finished |
| ctrl0_o | output | N_CLUSTERS*8 | Control-0 words (reset-disable bits) |
| ctrl1_o | output | N_CLUSTERS*8 | Control-1 words (snoop-inactive bit 0) |
| rst_ctrl_o | output | N_CLUSTERS*32 | Reset words, active low |
| por_rst_o | output | N_CLUSTERS*CORES_PER_CLUSTER | Core power-on resets, active low |
| pwr_gate_o | output | N_CLUSTERS*8 | Power-gate words, bit 4 cluster |

## Verification
The bench builds the arbiter with two clusters of four cores and shortens GATE_WAIT_US to 4. With a tick every fifth cycle, each cluster power-up finishes in a few dozen cycles, and the bench can count the ticks seen between the gate clear and the reset release exactly. Cluster 1 is little-type and cluster 0 is big-type, and the boot core is moved between resets. This way both reset masks and both reset-disable patterns are reached. The bench also covers out-of-range indices on each axis, repeat requests and joins into a powered cluster.

// File: rtl/cba_pkg.sv
package cba_pkg;

    localparam int CTL_W = 8;
    localparam int RST_W = 32;

    localparam int BIT_SNOOP   = 0;
    localparam int BIT_GATE_CL = 4;
    localparam int BIT_L2_RST  = 8;
    localparam int BIT_BUS_RST = 12;
    localparam int BIT_DBG0    = 16;
    localparam int BIT_TRC0    = 20;
    localparam int BIT_DSOC    = 24;
    localparam int BIT_RDIS_LT = 4;

    localparam logic [RST_W-1:0] RST_INIT  = 32'h01FF_11FF;
    localparam logic [CTL_W-1:0] CTL0_INIT = 8'h1F;
    localparam logic [CTL_W-1:0] GATE_INIT = 8'h1F;

    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_SNOOP_ON,
        STEP_POR_ALL,
        STEP_RST_ASSERT,
        STEP_RDIS_LOW,
        STEP_GATE_OPEN,
        STEP_RST_RELEASE,
        STEP_SNOOP_OFF
    } step_e;

    typedef enum logic [3:0] {
        S_IDLE, S_SNOOP_ON, S_POR, S_RST, S_RDIS, S_GATE,
        S_WAIT, S_REL, S_SNOOP_OFF, S_CORE, S_CWAIT, S_FIN
    } fsm_e;

    function automatic logic [RST_W-1:0] rst_assert_mask(input logic little, input int cores);
        logic [RST_W-1:0] m;
        m = '0;
        m[BIT_DSOC]    = 1'b1;
        m[BIT_BUS_RST] = 1'b1;
        m[BIT_L2_RST]  = 1'b1;
        for (int i = 0; i < cores; i++) begin
            m[BIT_DBG0 + i] = 1'b1;
            if (little) m[BIT_TRC0 + i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [RST_W-1:0] rst_release_mask();
        logic [RST_W-1:0] m;
        m = '0;
        m[BIT_DSOC]    = 1'b1;
        m[BIT_BUS_RST] = 1'b1;
        m[BIT_L2_RST]  = 1'b1;
        return m;
    endfunction

    function automatic logic [CTL_W-1:0] rdis_mask(input logic little, input int cores);
        logic [CTL_W-1:0] m;
        m = '0;
        if (little) begin
            for (int i = 0; i < cores; i++) m[i] = 1'b1;
            m[BIT_RDIS_LT] = 1'b1;
        end else begin
            m[0] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cba_count_table.sv
module cba_count_table #(
    parameter int N_CLUSTERS        = 2,
    parameter int CORES_PER_CLUSTER = 4,
    parameter int CNT_W             = 4,
    parameter int CL_W              = 1,
    parameter int CO_W              = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CL_W-1:0] boot_cl,
    input  logic [CO_W-1:0] boot_co,
    input  logic [CL_W-1:0] rd_cl,
    input  logic [CO_W-1:0] rd_co,
    input  logic            inc_en,
    input  logic [CL_W-1:0] inc_cl,
    input  logic [CO_W-1:0] inc_co,
    output logic            core_online,
    output logic            cluster_empty
);
    logic [CNT_W-1:0] cnt_q [N_CLUSTERS][CORES_PER_CLUSTER];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < N_CLUSTERS; c++)
                for (int k = 0; k < CORES_PER_CLUSTER; k++)
                    cnt_q[c][k] <= '0;
            cnt_q[boot_cl][boot_co] <= CNT_W'(1);
        end else if (inc_en && (cnt_q[inc_cl][inc_co] != '1)) begin
            cnt_q[inc_cl][inc_co] <= cnt_q[inc_cl][inc_co] + CNT_W'(1);
        end
    end

    always_comb begin
        cluster_empty = 1'b1;
        for (int k = 0; k < CORES_PER_CLUSTER; k++)
            if (cnt_q[rd_cl][k] != '0) cluster_empty = 1'b0;
        core_online = (cnt_q[rd_cl][rd_co] != '0);
    end

    for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_cl
        for (genvar k = 0; k < CORES_PER_CLUSTER; k++) begin : g_co
            // R9: a count only holds or steps up by one
            a_r9_count_steps: assert property (@(posedge clk) disable iff (rst)
                (cnt_q[c][k] == $past(cnt_q[c][k])) ||
                (cnt_q[c][k] == $past(cnt_q[c][k]) + CNT_W'(1)));
        end
    end
endmodule

// File: rtl/cba_us_timer.sv
module cba_us_timer #(
    parameter int WAIT_US = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(WAIT_US + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + CW'(1);
    end

    assign expired = run && tick && (cnt_q == CW'(WAIT_US - 1));

    // R8: the settle counter never passes the wait length
    a_r8_wait_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < CW'(WAIT_US)));
endmodule

// File: rtl/cba_cluster_regs.sv
module cba_cluster_regs import cba_pkg::*; #(
    parameter int CORES_PER_CLUSTER = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  step_e                        step,
    input  logic                         little,
    output logic [CTL_W-1:0]             ctrl0,
    output logic [CTL_W-1:0]             ctrl1,
    output logic [RST_W-1:0]             rstc,
    output logic [CORES_PER_CLUSTER-1:0] por,
    output logic [CTL_W-1:0]             gate
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0 <= CTL0_INIT;
            ctrl1 <= '0;
            rstc  <= RST_INIT;
            por   <= '1;
            gate  <= GATE_INIT;
        end else begin
            unique case (step)
                STEP_SNOOP_ON:    ctrl1[BIT_SNOOP] <= 1'b1;
                STEP_POR_ALL:     por <= '0;
                STEP_RST_ASSERT:  rstc <= rstc & ~rst_assert_mask(little, CORES_PER_CLUSTER);
                STEP_RDIS_LOW:    ctrl0 <= ctrl0 & ~rdis_mask(little, CORES_PER_CLUSTER);
                STEP_GATE_OPEN:   gate[BIT_GATE_CL] <= 1'b0;
                STEP_RST_RELEASE: rstc <= rstc | rst_release_mask();
                STEP_SNOOP_OFF:   ctrl1[BIT_SNOOP] <= 1'b0;
                default: ;
            endcase
        end
    end

    // R8: the gate opens only with snoops masked, resets held and core resets low
    a_r8_gate_after_resets: assert property (@(posedge clk) disable iff (rst)
        $fell(gate[BIT_GATE_CL]) |-> (ctrl1[BIT_SNOOP] && !rstc[BIT_L2_RST] &&
                                     (por == '0) && !ctrl0[0]));
    // R5: snoop-inactive drops only after the resets are released
    a_r5_snoop_off_last: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl1[BIT_SNOOP]) |-> (rstc[BIT_DSOC] && rstc[BIT_BUS_RST] &&
                                    rstc[BIT_L2_RST] && !gate[BIT_GATE_CL]));
endmodule

// File: rtl/cluster_boot_arbiter.sv
module cluster_boot_arbiter import cba_pkg::*; #(
    parameter  int N_CLUSTERS        = 2,
    parameter  int CORES_PER_CLUSTER = 4,
    parameter  int CNT_W             = 4,
    parameter  int GATE_WAIT_US      = 20,
    localparam int CL_W  = (N_CLUSTERS > 1) ? $clog2(N_CLUSTERS) : 1,
    localparam int CO_W  = (CORES_PER_CLUSTER > 1) ? $clog2(CORES_PER_CLUSTER) : 1,
    localparam int CL_IW = CL_W + 1,
    localparam int CO_IW = CO_W + 1
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic [CL_W-1:0]                         boot_cluster_i,
    input  logic [CO_W-1:0]                         boot_core_i,
    input  logic [N_CLUSTERS-1:0]                   cluster_little_i,
    input  logic                                    us_tick_i,
    input  logic                                    req_valid_i,
    output logic                                    req_ready_o,
    input  logic [CL_IW-1:0]                        req_cluster_i,
    input  logic [CO_IW-1:0]                        req_core_i,
    output logic                                    done_o,
    output logic                                    err_o,
    output logic                                    first_comer_o,
    output logic                                    core_start_o,
    output logic [CL_W-1:0]                         core_start_cluster_o,
    output logic [CO_W-1:0]                         core_start_core_o,
    input  logic                                    core_seq_done_i,
    output logic [N_CLUSTERS*CTL_W-1:0]             ctrl0_o,
    output logic [N_CLUSTERS*CTL_W-1:0]             ctrl1_o,
    output logic [N_CLUSTERS*RST_W-1:0]             rst_ctrl_o,
    output logic [N_CLUSTERS*CORES_PER_CLUSTER-1:0] por_rst_o,
    output logic [N_CLUSTERS*CTL_W-1:0]             pwr_gate_o
);
    typedef struct packed {
        logic [CL_W-1:0] cl;
        logic [CO_W-1:0] co;
        logic            err;
    } req_t;

    fsm_e  state_q, state_d;
    req_t  req_q;
    logic  first_q;
    step_e step;
    logic  idx_ok, online, empty, wait_done;
    logic [CTL_W-1:0] ctrl1_a [N_CLUSTERS];
    logic [CTL_W-1:0] gate_a  [N_CLUSTERS];

    assign idx_ok = (req_cluster_i < CL_IW'(N_CLUSTERS)) &&
                    (req_core_i < CO_IW'(CORES_PER_CLUSTER));

    cba_count_table #(
        .N_CLUSTERS(N_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
        .CNT_W(CNT_W), .CL_W(CL_W), .CO_W(CO_W)
    ) u_table (
        .clk(clk), .rst(rst),
        .boot_cl(boot_cluster_i), .boot_co(boot_core_i),
        .rd_cl(req_cluster_i[CL_W-1:0]), .rd_co(req_core_i[CO_W-1:0]),
        .inc_en((state_q == S_FIN) && !req_q.err),
        .inc_cl(req_q.cl), .inc_co(req_q.co),
        .core_online(online), .cluster_empty(empty)
    );

    cba_us_timer #(.WAIT_US(GATE_WAIT_US)) u_timer (
        .clk(clk), .rst(rst), .run(state_q == S_WAIT),
        .tick(us_tick_i), .expired(wait_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid_i) begin
                if (!idx_ok || online) state_d = S_FIN;
                else if (empty)        state_d = S_SNOOP_ON;
                else                   state_d = S_CORE;
            end
            S_SNOOP_ON:  state_d = S_POR;
            S_POR:       state_d = S_RST;
            S_RST:       state_d = S_RDIS;
            S_RDIS:      state_d = S_GATE;
            S_GATE:      state_d = S_WAIT;
            S_WAIT:      if (wait_done) state_d = S_REL;
            S_REL:       state_d = S_SNOOP_OFF;
            S_SNOOP_OFF: state_d = S_CORE;
            S_CORE:      state_d = S_CWAIT;
            S_CWAIT:     if (core_seq_done_i) state_d = S_FIN;
            S_FIN:       state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            S_SNOOP_ON:  step = STEP_SNOOP_ON;
            S_POR:       step = STEP_POR_ALL;
            S_RST:       step = STEP_RST_ASSERT;
            S_RDIS:      step = STEP_RDIS_LOW;
            S_GATE:      step = STEP_GATE_OPEN;
            S_REL:       step = STEP_RST_RELEASE;
            S_SNOOP_OFF: step = STEP_SNOOP_OFF;
            default:     step = STEP_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid_i) begin
                req_q.cl  <= req_cluster_i[CL_W-1:0];
                req_q.co  <= req_core_i[CO_W-1:0];
                req_q.err <= !idx_ok;
                if (idx_ok && !online) first_q <= empty;
            end
        end
    end

    for (genvar c = 0; c < N_CLUSTERS; c++) begin : g_cl
        cba_cluster_regs #(.CORES_PER_CLUSTER(CORES_PER_CLUSTER)) u_regs (
            .clk(clk), .rst(rst),
            .step((req_q.cl == CL_W'(c)) ? step : STEP_NONE),
            .little(cluster_little_i[c]),
            .ctrl0(ctrl0_o[c*CTL_W +: CTL_W]),
            .ctrl1(ctrl1_a[c]),
            .rstc(rst_ctrl_o[c*RST_W +: RST_W]),
            .por(por_rst_o[c*CORES_PER_CLUSTER +: CORES_PER_CLUSTER]),
            .gate(gate_a[c])
        );
        assign ctrl1_o[c*CTL_W +: CTL_W]    = ctrl1_a[c];
        assign pwr_gate_o[c*CTL_W +: CTL_W] = gate_a[c];
    end

    assign req_ready_o          = (state_q == S_IDLE);
    assign done_o               = (state_q == S_FIN);
    assign err_o                = done_o && req_q.err;
    assign first_comer_o        = first_q;
    assign core_start_o         = (state_q == S_CORE);
    assign core_start_cluster_o = req_q.cl;
    assign core_start_core_o    = req_q.co;

    // R10: an accepted request drops ready on the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o);
    // R4: the core start lasts a single cycle
    a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
        core_start_o |=> !core_start_o);
    // R3: a first comer is handed over only once its cluster is powered and coherent
    a_r3_first_powered: assert property (@(posedge clk) disable iff (rst)
        (core_start_o && first_comer_o) |->
            (!gate_a[req_q.cl][BIT_GATE_CL] && !ctrl1_a[req_q.cl][BIT_SNOOP]));
endmodule

// File: tb/cluster_boot_arbiter_tb.sv
module cluster_boot_arbiter_tb_top;
    localparam int N = 2;
    localparam int C = 4;
    localparam int W = 4;

    typedef struct {
        int cl;
        int co;
        bit err;
        bit start;
        bit first;
        bit pwr;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [0:0] boot_cl = '0;
    logic [1:0] boot_co = '0;
    logic [N-1:0] little = 2'b10;
    logic us_tick = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_cl = '0;
    logic [2:0] req_co = '0;
    logic done, err, first_comer, core_start, seq_done;
    logic [0:0] st_cl;
    logic [1:0] st_co;
    logic [N*8-1:0]  ctrl0, ctrl1, gate;
    logic [N*32-1:0] rstc;
    logic [N*C-1:0]  por;

    always #5 clk = ~clk;

    cluster_boot_arbiter #(
        .N_CLUSTERS(N), .CORES_PER_CLUSTER(C), .CNT_W(4), .GATE_WAIT_US(W)
    ) dut_i (
        .clk(clk), .rst(rst), .boot_cluster_i(boot_cl), .boot_core_i(boot_co),
        .cluster_little_i(little), .us_tick_i(us_tick),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_cluster_i(req_cl), .req_core_i(req_co),
        .done_o(done), .err_o(err), .first_comer_o(first_comer),
        .core_start_o(core_start), .core_start_cluster_o(st_cl),
        .core_start_core_o(st_co), .core_seq_done_i(seq_done),
        .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .rst_ctrl_o(rstc),
        .por_rst_o(por), .pwr_gate_o(gate)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    exp_t q[$];
    int   bcnt [N][C];
    bit   bfirst;
    logic [31:0] m_rst [N];
    logic [7:0]  m_c0 [N];
    logic [7:0]  m_gate [N];
    logic [C-1:0] m_por [N];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-core sequencer model: done three cycles after the start
    int cd = 0;
    always @(posedge clk) begin
        #1;
        if (core_start) cd = 3;
        else if (cd > 0) cd--;
        seq_done = (cd == 1);
    end

    // microsecond tick every fifth cycle
    int tc = 0;
    always @(posedge clk) begin
        #1;
        tc = (tc == 4) ? 0 : tc + 1;
        us_tick = (tc == 0);
    end

    task automatic model_reset(input int bc, input int bo);
        for (int c = 0; c < N; c++) begin
            for (int k = 0; k < C; k++) bcnt[c][k] = 0;
            m_rst[c] = 32'h01FF_11FF;
            m_c0[c] = 8'h1F;
            m_gate[c] = 8'h1F;
            m_por[c] = '1;
        end
        bcnt[bc][bo] = 1;
        bfirst = 0;
    endtask

    task automatic do_reset(input int bc, input int bo);
        @(posedge clk); #1;
        rst = 1'b1;
        boot_cl = 1'(bc);
        boot_co = 2'(bo);
        model_reset(bc, bo);
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic issue(input int cl, input int co);
        exp_t e;
        int occ;
        e.cl = cl; e.co = co; e.err = 0; e.start = 0; e.pwr = 0;
        if (cl >= N || co >= C) begin
            e.err = 1;
        end else if (bcnt[cl][co] != 0) begin
            e.start = 0;
        end else begin
            occ = 0;
            for (int k = 0; k < C; k++) occ += bcnt[cl][k];
            e.start = 1;
            e.pwr = (occ == 0);
            bfirst = e.pwr;
            if (e.pwr) begin
                m_rst[cl] = m_rst[cl] & ~(32'h010F_1100 | (little[cl] ? 32'h00F0_0000 : 32'h0));
                m_rst[cl] = m_rst[cl] | 32'h0100_1100;
                m_c0[cl] = m_c0[cl] & (little[cl] ? 8'hE0 : 8'hFE);
                m_gate[cl] = m_gate[cl] & 8'hEF;
                m_por[cl] = '0;
            end
        end
        e.first = bfirst;
        if (!e.err) bcnt[cl][co]++;
        q.push_back(e);
        @(posedge clk); #1;
        while (!req_ready) begin @(posedge clk); #1; end
        req_cl = 2'(cl);
        req_co = 3'(co);
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
    endtask

    // monitor / scoreboard
    bit busy = 0;
    bit ready_bad = 0;
    int starts = 0;
    int ticks [N];
    bit snoop_seen [N];
    always @(negedge clk) begin
        if (rst) begin
            busy = 0; ready_bad = 0; starts = 0;
            for (int c = 0; c < N; c++) begin ticks[c] = 0; snoop_seen[c] = 0; end
        end else begin
            for (int c = 0; c < N; c++) begin
                if (!gate[c*8+4] && !rstc[c*32+8] && us_tick) ticks[c]++;
                if (ctrl1[c*8]) snoop_seen[c] = 1;
            end
            if (core_start) begin
                starts++;
                if (q.size() != 0) begin
                    chk("R4 start cluster", 32'(st_cl), 32'(q[0].cl));
                    chk("R4 start core", 32'(st_co), 32'(q[0].co));
                end
            end
            if (busy && req_ready && !done) ready_bad = 1;
            if (done) begin
                if (q.size() == 0) begin
                    chk("R4 unexpected done", 32'(1), 32'(0));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R1 err flag", 32'(err), 32'(e.err));
                    chk("R3 first comer", 32'(first_comer), 32'(e.first));
                    chk("R4 core starts", 32'(starts), 32'(e.start));
                    chk("R10 ready low while busy", 32'(ready_bad), 32'(0));
                    for (int c = 0; c < N; c++) begin
                        chk("R6 reset word", rstc[c*32 +: 32], m_rst[c]);
                        chk("R7 ctrl0 word", 32'(ctrl0[c*8 +: 8]), 32'(m_c0[c]));
                        chk("R5 ctrl1 word", 32'(ctrl1[c*8 +: 8]), 32'(0));
                        chk("R8 gate word", 32'(gate[c*8 +: 8]), 32'(m_gate[c]));
                        chk("R8 por vector", 32'(por[c*C +: C]), 32'(m_por[c]));
                        chk("R5 snoop raised only on power-up", 32'(snoop_seen[c]),
                            32'(e.pwr && e.cl == c));
                        snoop_seen[c] = 0;
                    end
                    if (e.pwr) chk("R8 gate wait ticks", 32'(ticks[e.cl]), 32'(W));
                end
                busy = 0; ready_bad = 0; starts = 0;
            end
            if (req_valid && req_ready) busy = 1;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // phase 1: core 1 of big cluster 0 online at reset, cluster 1 little
        do_reset(0, 1);
        @(negedge clk);
        chk("R10 ready after reset", 32'(req_ready), 32'(1));
        chk("R4 done low after reset", 32'(done), 32'(0));
        chk("R6 reset word init", rstc[31:0], 32'h01FF_11FF);
        chk("R7 ctrl0 init", 32'(ctrl0[7:0]), 32'h1F);
        chk("R8 gate init", 32'(gate[15:8]), 32'h1F);
        chk("R8 por init", 32'(por[7:4]), 32'hF);
        issue(0, 1);   // R11 boot core already counted: R2 path
        issue(0, 2);   // R3 join a live cluster, first comer low
        issue(0, 2);   // R9 repeat is counted
        issue(2, 0);   // R1 cluster out of range
        issue(1, 4);   // R1 core out of range
        issue(3, 7);   // R1 both out of range
        issue(1, 3);   // R3 R5 R6 R7 R8 little cluster power-up
        issue(1, 0);   // R3 second core, no power-up
        issue(1, 3);   // R9 R2 repeat
        // phase 2: boot core moves to cluster 1, big cluster 0 is empty
        do_reset(1, 0);
        issue(0, 0);   // R6 R7 big cluster power-up
        issue(0, 0);   // R2 repeat
        issue(0, 3);   // R3 join
        issue(1, 2);   // R11 cluster 1 counted as live at reset
        issue(1, 0);   // R11 boot core count is 1
        repeat (5) @(posedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule